// File: doc/BRIEF.md
# Page-Mode Write Load Controller

This block sits behind the write strobes of a byte-wide nonvolatile memory model with 13 address bits and 8 data bits. It watches chip enable, write enable and output enable, filters out strobes that are too short, and collects each qualified byte into a 32-entry page buffer. Each buffer slot has its own valid flag. A byte-load timer restarts after each accepted strobe. While the timer is running, further strobes extend the page.

When the load timer expires, the controller enters a self-timed program phase and raises `busy`. During this phase it sends the loaded bytes to an external array through a one-byte-per-cycle write port, in ascending slot order. Slots that were not loaded produce no write. When the program phase ends, the buffer is cleared and `busy` drops.

Writes are refused for a fixed inhibit period after reset and whenever the supply-low input is high. The address and data of the most recent accepted byte are kept for use by status logic. Every time interval is a parameter counted in clock cycles, so short values can be used in simulation.

Top module: `page_load_ctrl`

## Requirements
- R1: A byte is loaded only by a strobe during which `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold together. A strobe with `oe_n`=0 or with `ce_n`=1 loads nothing.
- R2: The address is taken in the first cycle of the combined strobe. The data is taken in the last cycle of the strobe.
- R3: Address bits [12:5] of the last accepted load select the page for every committed byte. Bits [4:0] select the slot, and slots may be loaded in any order.
- R4: `busy` rises exactly LOAD_TO cycles after the clock edge that ends the last accepted strobe. A new accepted strobe within that window restarts the count.
- R5: Only loaded slots are committed. If a slot is loaded twice, it commits once, with the later data.
- R6: A strobe shorter than MIN_PULSE cycles loads nothing. A strobe of exactly MIN_PULSE cycles is accepted.
- R7: `busy` stays high for exactly PROG_CYCLES cycles. Strobes that end while `busy` is high are ignored.
- R8: Strobes that end within INIT_CYCLES cycles after reset, or while `supply_low`=1, are ignored.
- R9: `last_addr` and `last_data` hold the full address and data of the most recent accepted load. Both are 0 after reset.
- R10: After reset, `busy` and `mem_we` are 0.
- R11: `mem_we` pulses only while `busy` is high, at most once per cycle, with slots in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writing |
| supply_low | input | 1 | Supply below write threshold; blocks loads |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| busy | output | 1 | Program phase in progress |
| mem_we | output | 1 | Commit strobe to the array |
| mem_addr | output | 13 | Commit address |
| mem_data | output | 8 | Commit data |
| last_addr | output | 13 | Address of last accepted load |
| last_data | output | 8 | Data of last accepted load |

## Verification
Faults inside the block show up at the ports in predictable ways:
- A stuck or stale valid flag produces an extra commit, or a missing one, within the first 32 cycles of the next program phase.
- A wrong page register shows up in the upper bits of `mem_addr` in those same cycles.
- A load timer that does not restart, or that keeps counting during a strobe, moves the rise of `busy` away from its exact cycle.
- An inhibit or supply gate that leaks shows up as a change in `last_addr` and `last_data` one cycle after the strobe ends, and as an unexpected program phase LOAD_TO cycles later.

// File: rtl/plc_pkg.sv
package plc_pkg;
    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_PROG = 1'b1
    } plc_state_e;
endpackage

// File: rtl/plc_strobe_filter.sv
// Combined strobe detector: address at first active cycle, data at last,
// qualified by a minimum active length.
module plc_strobe_filter #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              in_pulse,
    output logic              done,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    localparam int LEN_W = $clog2(MIN_PULSE + 1) < 1 ? 1 : $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic              active;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } strobe_t;

    strobe_t s_d, s_q;
    logic    act;

    always_comb begin
        act = ~ce_n & ~we_n & oe_n;
        s_d = s_q;
        s_d.active = act;
        if (act) begin
            s_d.data = din;
            if (!s_q.active) begin
                s_d.addr = addr;
                s_d.len  = LEN_W'(1);
            end else if (s_q.len < LEN_W'(MIN_PULSE)) begin
                s_d.len = s_q.len + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_pulse = s_q.active;
    assign done     = s_q.active & ~act & (s_q.len >= LEN_W'(MIN_PULSE));
    assign cap_addr = s_q.addr;
    assign cap_data = s_q.data;
endmodule

// File: rtl/plc_page_buf.sv
// Page buffer: one data byte and one valid flag per slot.
module plc_page_buf #(
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              any_valid
);
    localparam int PAGE = 1 << PAGE_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } slot_t;

    slot_t slot_q [PAGE];
    logic [PAGE-1:0] vld_vec;

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        slot_t slot_d;

        always_comb begin
            slot_d = slot_q[g];
            if (clr) begin
                slot_d.vld = 1'b0;
            end else if (wr_en && wr_idx == PAGE_W'(g)) begin
                slot_d.vld = 1'b1;
                slot_d.dat = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end

        assign vld_vec[g] = slot_q[g].vld;
    end

    assign rd_valid  = slot_q[rd_idx].vld;
    assign rd_data   = slot_q[rd_idx].dat;
    assign any_valid = |vld_vec;
endmodule

// File: rtl/page_load_ctrl.sv
// Page-mode write load controller top.
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 5,
    parameter int MIN_PULSE   = 2,
    parameter int LOAD_TO     = 10000,
    parameter int PROG_CYCLES = 500000,
    parameter int INIT_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int PAGE   = 1 << PAGE_W;
    localparam int PG_W   = ADDR_W - PAGE_W;
    localparam int TMR_W  = $clog2(LOAD_TO + 1);
    localparam int PRG_W  = $clog2(PROG_CYCLES + 1);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        plc_state_e        state;
        logic [TMR_W-1:0]  tmr;
        logic [PRG_W-1:0]  prg;
        logic [INIT_W-1:0] init_cnt;
        logic              init_done;
        logic [PG_W-1:0]   page;
        logic [ADDR_W-1:0] last_addr;
        logic [DATA_W-1:0] last_data;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic              in_pulse, done;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic              accept, clr;
    logic              rd_valid, any_valid;
    logic [DATA_W-1:0] rd_data;
    logic [PAGE_W-1:0] rd_idx;

    plc_strobe_filter #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MIN_PULSE(MIN_PULSE)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .in_pulse(in_pulse),
        .done    (done),
        .cap_addr(cap_addr),
        .cap_data(cap_data)
    );

    plc_page_buf #(
        .PAGE_W(PAGE_W),
        .DATA_W(DATA_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_idx   (cap_addr[PAGE_W-1:0]),
        .wr_data  (cap_data),
        .clr      (clr),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .any_valid(any_valid)
    );

    always_comb begin
        c_d    = c_q;
        clr    = 1'b0;
        accept = done && (c_q.state == ST_LOAD) && c_q.init_done && !supply_low;

        if (!c_q.init_done) begin
            if (c_q.init_cnt == INIT_W'(INIT_CYCLES - 1)) c_d.init_done = 1'b1;
            else                                          c_d.init_cnt  = c_q.init_cnt + INIT_W'(1);
        end

        case (c_q.state)
            ST_LOAD: begin
                if (accept) begin
                    c_d.tmr       = '0;
                    c_d.page      = cap_addr[ADDR_W-1:PAGE_W];
                    c_d.last_addr = cap_addr;
                    c_d.last_data = cap_data;
                end else if (any_valid && !in_pulse) begin
                    if (c_q.tmr == TMR_W'(LOAD_TO - 1)) begin
                        c_d.state = ST_PROG;
                        c_d.prg   = '0;
                        c_d.tmr   = '0;
                    end else begin
                        c_d.tmr = c_q.tmr + TMR_W'(1);
                    end
                end
            end
            ST_PROG: begin
                if (c_q.prg == PRG_W'(PROG_CYCLES - 1)) begin
                    c_d.state = ST_LOAD;
                    clr       = 1'b1;
                end else begin
                    c_d.prg = c_q.prg + PRG_W'(1);
                end
            end
            default: c_d.state = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_idx    = PAGE_W'(c_q.prg);
    assign busy      = (c_q.state == ST_PROG);
    assign mem_we    = busy && (32'(c_q.prg) < PAGE) && rd_valid;
    assign mem_addr  = {c_q.page, rd_idx};
    assign mem_data  = rd_data;
    assign last_addr = c_q.last_addr;
    assign last_data = c_q.last_data;
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_low,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r10: assert (!busy && !mem_we);
        end
    end

    p_commit_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == PROG_CYCLES);

    p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(last_addr) && $stable(last_data)));

    p_supply_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> ($stable(last_addr) && $stable(last_data)));

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W]));
endmodule

bind page_load_ctrl plc_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_W     (PAGE_W),
    .PROG_CYCLES(PROG_CYCLES)
) u_plc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_low(supply_low),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .last_addr (last_addr),
    .last_data (last_data)
);

// File: tb/tb_page_load_ctrl.sv
`timescale 1ns/1ps
module tb_page_load_ctrl;
    localparam int MIN_PULSE   = 3;
    localparam int LOAD_TO     = 20;
    localparam int PROG_CYCLES = 50;
    localparam int INIT_CYCLES = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic        busy, mem_we;
    logic [12:0] mem_addr, last_addr;
    logic [7:0]  mem_data, last_data;

    int n_checks = 0, n_fail = 0;
    int ncap = 0, busy_len = 0;
    logic [12:0] cap_a [64];
    logic [7:0]  cap_d [64];

    always #5 clk = ~clk;

    page_load_ctrl #(
        .MIN_PULSE  (MIN_PULSE),
        .LOAD_TO    (LOAD_TO),
        .PROG_CYCLES(PROG_CYCLES),
        .INIT_CYCLES(INIT_CYCLES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_low(supply_low), .addr(addr), .din(din), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .last_addr(last_addr), .last_data(last_data)
    );

    always @(negedge clk) begin
        if (rst_n && mem_we && ncap < 64) begin
            cap_a[ncap] = mem_addr;
            cap_d[ncap] = mem_data;
            ncap = ncap + 1;
        end
        if (rst_n && busy) busy_len = busy_len + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Data is wrong in every cycle but the last; address is right only in the first.
    task automatic strobe(input logic [12:0] a, input logic [7:0] d, input int len,
                          input bit oe_low, input bit ce_high);
        @(negedge clk);
        addr = a;
        for (int i = 0; i < len; i++) begin
            if (i > 0) addr = a ^ 13'h1FFF;
            din  = (i == len - 1) ? d : ~d;
            ce_n = ce_high;
            we_n = 1'b0;
            oe_n = !oe_low;
            @(negedge clk);
        end
        we_n = 1'b1;
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < PROG_CYCLES + LOAD_TO + 10 && !busy; i++) @(negedge clk);
        for (int i = 0; i < PROG_CYCLES + 10 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!busy, "R10 busy after reset", busy, 0);
        check(!mem_we, "R10 mem_we after reset", mem_we, 0);
    endtask

    task automatic t_init_inhibit();
        @(negedge clk);
        rst_n = 1'b1;
        strobe(13'h0101, 8'h3C, 3, 0, 0);
        idle(LOAD_TO + 5);
        check(!busy && ncap == 0, "R8 load during init inhibit", ncap, 0);
        check(last_addr == 13'h0, "R9 last_addr after reset", last_addr, 0);
        check(last_data == 8'h0, "R9 last_data after reset", last_data, 0);
        idle(10);
    endtask

    task automatic t_page();
        logic [12:0] e_a [3];
        logic [7:0]  e_d [3];
        e_a[0] = {8'h12, 5'd3};  e_d[0] = 8'h11;
        e_a[1] = {8'h12, 5'd5};  e_d[1] = 8'h5A;
        e_a[2] = {8'h12, 5'd31}; e_d[2] = 8'hC3;
        ncap = 0;
        busy_len = 0;
        strobe({8'h07, 5'd3}, 8'h11, MIN_PULSE, 0, 0);
        idle(15);
        strobe({8'h12, 5'd31}, 8'hC3, 4, 0, 0);
        idle(15);
        strobe({8'h12, 5'd5}, 8'h5A, MIN_PULSE, 0, 0);
        idle(LOAD_TO);
        check(!busy, "R4 busy one cycle before timeout", busy, 0);
        idle(1);
        check(busy, "R4 busy at timeout", busy, 1);
        wait_done();
        check(busy_len == PROG_CYCLES, "R7 busy length", busy_len, PROG_CYCLES);
        check(ncap == 3, "R5 commit count", ncap, 3);
        for (int i = 0; i < 3; i++) begin
            check(cap_a[i] == e_a[i], "R3 R11 commit address", cap_a[i], e_a[i]);
            check(cap_d[i] == e_d[i], "R2 commit data", cap_d[i], e_d[i]);
        end
        check(last_addr == {8'h12, 5'd5}, "R9 last_addr", last_addr, {8'h12, 5'd5});
        check(last_data == 8'h5A, "R9 last_data", last_data, 8'h5A);
    endtask

    task automatic t_dup_and_busy();
        ncap = 0;
        strobe({8'h03, 5'd4}, 8'hAA, 3, 0, 0);
        idle(3);
        strobe({8'h03, 5'd4}, 8'hBB, 3, 0, 0);
        for (int i = 0; i < LOAD_TO + 10 && !busy; i++) @(negedge clk);
        strobe({8'h03, 5'd9}, 8'h77, 3, 0, 0);
        wait_done();
        check(ncap == 1, "R5 duplicate slot commits once", ncap, 1);
        check(cap_a[0] == {8'h03, 5'd4}, "R5 duplicate address", cap_a[0], {8'h03, 5'd4});
        check(cap_d[0] == 8'hBB, "R5 later data kept", cap_d[0], 8'hBB);
        idle(LOAD_TO + 5);
        check(!busy && ncap == 1, "R7 load during busy ignored", ncap, 1);
        check(last_data == 8'hBB, "R7 last_data unchanged", last_data, 8'hBB);
    endtask

    task automatic t_ignored(input string req, input int len, input bit oe_low,
                             input bit ce_high, input bit sup);
        logic [12:0] la;
        la = last_addr;
        ncap = 0;
        supply_low = sup;
        strobe(13'h1ABC, 8'h96, len, oe_low, ce_high);
        @(negedge clk);
        supply_low = 1'b0;
        idle(LOAD_TO + 5);
        check(!busy, {req, " no program"}, busy, 0);
        check(ncap == 0, {req, " no commit"}, ncap, 0);
        check(last_addr == la, {req, " last_addr kept"}, last_addr, la);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        idle(3);
        t_reset();
        t_init_inhibit();
        t_page();
        t_dup_and_busy();
        t_ignored("R6 short strobe", MIN_PULSE - 1, 0, 0, 0);
        t_ignored("R1 oe low", 4, 1, 0, 0);
        t_ignored("R1 ce high", 4, 0, 1, 0);
        t_ignored("R8 supply low", 4, 0, 0, 1);
        report();
    end
endmodule